// File: doc/BRIEF.md
# Peripheral DMA Channel Controller

This block is one DMA channel that moves data between an externally attached peripheral and memory, one item at a time. Software sets it up through four word registers: a destination address, a transfer count, a control word and a status word. The peripheral asks for service with a request line. The channel answers with an acknowledge in the same cycle. On the final transfer it also drives a terminal-count strobe.

The memory side is a single address with a write or read strobe and a ready input. When the direction bit is 1, peripheral data goes straight to memory. When it is 0, memory data goes straight to the peripheral. The channel never packs or unpacks data, so the programmed transfer width must match the peripheral's bus width.

The channel also handles the rest of the transfer bookkeeping:
- It advances the address by the transfer width in bytes.
- It counts the transfers down.
- It refuses to run from a misaligned address and reports an alignment error instead.
- It can check per-byte parity on incoming peripheral data.
- It latches completion and error conditions in write-1-to-clear status bits.

Top module: `pdma_channel`

## Requirements
- R1: After reset, every register reads zero, and acknowledge, terminal count and both memory strobes are low.
- R2: The register map is as follows:
  - Address 0 holds the destination address.
  - Address 1 holds the count.
  - Address 2 holds the control word. Bit 0 is enable, bits 2:1 are the width code, bit 3 is address increment, bits 5:4 are the mode, bit 6 is the location, bit 7 is the direction, bit 8 is parity enable and bit 9 is buffer enable.
  - Address 3 holds status. Bit 0 is done, bit 1 is alignment error and bit 2 is parity error.
  - Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R3: The acknowledge is high in a cycle only when all of the following hold: the channel is enabled, the count is nonzero, the mode is 00, the location bit is 0, the address is aligned, the request is high and memory ready is high.
- R4: Direction 1 moves data from the peripheral to memory. In an acknowledged cycle the channel raises the memory write strobe with the peripheral data on the memory write bus. Direction 0 moves data from memory to the peripheral. In an acknowledged cycle the channel raises the memory read strobe and passes the memory read data to the peripheral data output, which is otherwise zero. The two strobes are never high together.
- R5: The width code sets the byte step: 00 is 1 byte, 01 is 2 bytes, and 10 or 11 is 4 bytes. Each completed transfer advances the address by this step when increment is set. When increment is clear, the address holds.
- R6: Each completed transfer decrements the count by one. On the transfer that takes the count from 1 to 0, terminal count is high together with the acknowledge and low in the next cycle. That transfer also sets done and clears enable.
- R7: The channel checks alignment whenever it is enabled, the count is nonzero and the mode and location select an external peripheral. If the address is not a multiple of the byte step, the channel gives no acknowledge, sets the alignment error bit and clears enable. The count and address stay unchanged.
- R8: Parity is checked when parity enable and direction 1 are both set. For each active byte lane i (below the byte step), the parity bit i must equal the XOR of data bits 8i+7..8i. On a mismatch the request is still acknowledged, but there is no memory write. The parity error bit is set, enable is cleared, and the count and address are unchanged. When parity enable is clear, parity bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| preq | input | 1 | Peripheral request |
| pack | output | 1 | Peripheral acknowledge |
| ptc | output | 1 | Terminal count, final transfer only |
| pdata_in | input | DW | Data from peripheral |
| ppar_in | input | DW/8 | Per-byte parity from peripheral |
| pdata_out | output | DW | Data to peripheral |
| maddr | output | AW | Memory address |
| mwr | output | 1 | Memory write strobe |
| mrd | output | 1 | Memory read strobe |
| mwdata | output | DW | Memory write data |
| mrdata | input | DW | Memory read data |
| mready | input | 1 | Memory ready |

## Verification
The assertions check on every cycle that:
- the acknowledge appears only with request and ready;
- the two memory strobes never overlap;
- terminal count lasts exactly one cycle, comes with an acknowledge and leads to done;
- an alignment fault or parity fault stops the channel in the next cycle.

Only the bench scenarios can show the following:
- the address steps for each width and increment setting;
- the transfer counts;
- the data routing in both directions;
- the write-1-to-clear behaviour;
- that parity bits are ignored when parity checking is off.

The bench shows these by comparing each cycle against a model of address and count.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [1:0] {
        WID_B1  = 2'b00,
        WID_B2  = 2'b01,
        WID_B4  = 2'b10,
        WID_B4X = 2'b11
    } width_e;

    // Field order matches control word bits 9..0
    typedef struct packed {
        logic       buf_en;
        logic       par_en;
        logic       dir;
        logic       loc;
        logic [1:0] mode;
        logic       dinc;
        width_e     width;
        logic       en;
    } ctrl_t;

    // Field order matches status word bits 2..0
    typedef struct packed {
        logic par_err;
        logic align_err;
        logic done;
    } stat_t;

    localparam logic [1:0] RA_DEST = 2'd0;
    localparam logic [1:0] RA_CNT  = 2'd1;
    localparam logic [1:0] RA_CTRL = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    localparam int CTRL_BITS = $bits(ctrl_t);
    localparam int STAT_BITS = $bits(stat_t);

endpackage

// File: rtl/pdma_align_chk.sv
module pdma_align_chk
    import pdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  width_e          width,
    input  logic [AW-1:0]   addr,
    output logic [AW-1:0]   step,
    output logic            aligned
);
    logic [AW-1:0] mask;

    always_comb begin
        unique case (width)
            WID_B1:  step = AW'(1);
            WID_B2:  step = AW'(2);
            default: step = AW'(4);
        endcase
        mask    = step - AW'(1);
        aligned = ((addr & mask) == '0);
    end
endmodule

// File: rtl/pdma_parity_chk.sv
module pdma_parity_chk
    import pdma_pkg::*;
#(
    parameter int DW = 32
) (
    input  width_e           width,
    input  logic [DW-1:0]    data,
    input  logic [DW/8-1:0]  par,
    output logic             ok
);
    localparam int LANES = DW / 8;

    logic [LANES-1:0] lane_used;
    logic [LANES-1:0] lane_ok;

    always_comb begin
        unique case (width)
            WID_B1:  lane_used = LANES'(4'b0001);
            WID_B2:  lane_used = LANES'(4'b0011);
            default: lane_used = LANES'(4'b1111);
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_ok[i] = !lane_used[i] || (par[i] == ^data[i*8 +: 8]);
    end

    assign ok = &lane_ok;
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              preq,
    output logic              pack,
    output logic              ptc,
    input  logic [DW-1:0]     pdata_in,
    input  logic [DW/8-1:0]   ppar_in,
    output logic [DW-1:0]     pdata_out,
    output logic [AW-1:0]     maddr,
    output logic              mwr,
    output logic              mrd,
    output logic [DW-1:0]     mwdata,
    input  logic [DW-1:0]     mrdata,
    input  logic              mready
);
    localparam int RW = 32;

    typedef struct packed {
        logic [AW-1:0] dest;
        logic [CW-1:0] cnt;
        ctrl_t         ctrl;
        stat_t         stat;
    } chan_t;

    chan_t st_d, st_q;

    logic [AW-1:0] step;
    logic          aligned;
    logic          par_ok;
    logic          armed;
    logic          run;
    logic          xfer;
    logic          par_bad;
    logic          good;
    logic          last;
    logic          align_fault;

    pdma_align_chk #(.AW(AW)) u_align (
        .width   (st_q.ctrl.width),
        .addr    (st_q.dest),
        .step    (step),
        .aligned (aligned)
    );

    pdma_parity_chk #(.DW(DW)) u_par (
        .width (st_q.ctrl.width),
        .data  (pdata_in),
        .par   (ppar_in),
        .ok    (par_ok)
    );

    always_comb begin
        armed       = st_q.ctrl.en && (st_q.cnt != '0)
                      && (st_q.ctrl.mode == 2'b00) && !st_q.ctrl.loc;
        run         = armed && aligned;
        align_fault = armed && !aligned;
        xfer        = run && preq && mready;
        par_bad     = xfer && st_q.ctrl.dir && st_q.ctrl.par_en && !par_ok;
        good        = xfer && !par_bad;
        last        = (st_q.cnt == CW'(1));

        pack      = xfer;
        ptc       = good && last;
        mwr       = good && st_q.ctrl.dir;
        mrd       = xfer && !st_q.ctrl.dir;
        maddr     = st_q.dest;
        mwdata    = pdata_in;
        pdata_out = mrd ? mrdata : '0;

        unique case (reg_addr)
            RA_DEST: reg_rdata = RW'(st_q.dest);
            RA_CNT:  reg_rdata = RW'(st_q.cnt);
            RA_CTRL: reg_rdata = RW'(st_q.ctrl);
            default: reg_rdata = RW'(st_q.stat);
        endcase
    end

    always_comb begin
        st_d = st_q;

        // write-1-to-clear first, so events of this cycle win
        if (reg_wr && reg_addr == RA_STAT) begin
            st_d.stat = st_q.stat & ~stat_t'(reg_wdata[STAT_BITS-1:0]);
        end

        if (good) begin
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.ctrl.dinc) begin
                st_d.dest = st_q.dest + step;
            end
            if (last) begin
                st_d.ctrl.en   = 1'b0;
                st_d.stat.done = 1'b1;
            end
        end

        if (par_bad) begin
            st_d.ctrl.en      = 1'b0;
            st_d.stat.par_err = 1'b1;
        end

        if (align_fault) begin
            st_d.ctrl.en        = 1'b0;
            st_d.stat.align_err = 1'b1;
        end

        // software writes to setup registers override channel updates
        if (reg_wr) begin
            unique case (reg_addr)
                RA_DEST: st_d.dest = reg_wdata[AW-1:0];
                RA_CNT:  st_d.cnt  = reg_wdata[CW-1:0];
                RA_CTRL: st_d.ctrl = ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_ack_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pack |-> (preq && mready && st_q.ctrl.en && st_q.cnt != '0));

    assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mwr && mrd));

    assert_tc_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptc |=> !ptc);

    assert_tc_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptc |-> pack);

    assert_tc_sets_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptc |=> st_q.stat.done);

    assert_align_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (align_fault && !reg_wr) |=> (!st_q.ctrl.en && st_q.stat.align_err));

    assert_parity_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (par_bad && !reg_wr) |=> (!st_q.ctrl.en && st_q.stat.par_err
                                  && $stable(st_q.cnt)));
endmodule

// File: tb/pdma_channel_tb.sv
module pdma_channel_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            preq = 1'b0;
    logic            pack, ptc;
    logic [DW-1:0]   pdata_in = '0;
    logic [DW/8-1:0] ppar_in = '0;
    logic [DW-1:0]   pdata_out;
    logic [AW-1:0]   maddr;
    logic            mwr, mrd;
    logic [DW-1:0]   mwdata;
    logic [DW-1:0]   mrdata = '0;
    logic            mready = 1'b0;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    pdma_channel #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
        .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
        .preq, .pack, .ptc, .pdata_in, .ppar_in, .pdata_out,
        .maddr, .mwr, .mrd, .mwdata, .mrdata, .mready
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, input logic [1:0] w, input bit dinc,
                                              input logic [1:0] mode, input bit loc, input bit dir,
                                              input bit pen);
        return {22'd0, 1'b0, pen, dir, loc, mode, dinc, w, en};
    endfunction

    function automatic int step_of(input logic [1:0] w);
        return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [3:0] good_par(input logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog R1 act=hung exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_0042));
        #22 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), r);
            chk(r == 0, "R1 reset register", r, 0);
        end
        chk(!pack && !ptc && !mwr && !mrd, "R1 reset outputs", {pack, ptc, mwr, mrd}, 0);

        // R2 register readback
        wr_reg(2'd0, 32'hDEAD_BEE0);
        rd_reg(2'd0, r); chk(r == 32'hDEAD_BEE0, "R2 dest readback", r, 32'hDEAD_BEE0);
        wr_reg(2'd2, 32'h0000_03FE);
        rd_reg(2'd2, r); chk(r == 32'h0000_03FE, "R2 ctrl readback", r, 32'h3FE);
        wr_reg(2'd2, 0);

        // R3 mode/location gating
        wr_reg(2'd0, 32'h100);
        wr_reg(2'd1, 4);
        wr_reg(2'd2, ctrl_word(1, 2'b10, 1, 2'b01, 0, 1, 0));
        preq = 1; mready = 1; #1;
        chk(!pack, "R3 mode 01 blocks ack", pack, 0);
        wr_reg(2'd2, ctrl_word(1, 2'b10, 1, 2'b00, 1, 1, 0));
        #1; chk(!pack, "R3 external location required", pack, 0);
        preq = 0; mready = 0;
        wr_reg(2'd2, 0);

        // R7 misaligned start
        wr_reg(2'd0, 32'h101);
        wr_reg(2'd1, 3);
        @(negedge clk); preq = 1; mready = 1;
        reg_addr = 2'd2; reg_wdata = ctrl_word(1, 2'b01, 1, 2'b00, 0, 1, 0); reg_wr = 1;
        @(negedge clk); reg_wr = 0; #1;
        chk(!pack, "R7 no ack when misaligned", pack, 0);
        @(negedge clk); preq = 0; mready = 0;
        rd_reg(2'd3, r); chk(r[1] == 1'b1, "R7 align error set", r, 2);
        rd_reg(2'd2, r); chk(r[0] == 1'b0, "R7 enable cleared", r[0], 0);
        rd_reg(2'd1, r); chk(r == 3, "R7 count unchanged", r, 3);
        rd_reg(2'd0, r); chk(r == 32'h101, "R7 address unchanged", r, 32'h101);
        wr_reg(2'd3, 32'h0);
        rd_reg(2'd3, r); chk(r[1] == 1'b1, "R2 writing zero keeps status", r, 2);
        wr_reg(2'd3, 32'h7);
        rd_reg(2'd3, r); chk(r == 0, "R2 write-one clears status", r, 0);

        // R8 parity fault
        wr_reg(2'd0, 32'h200);
        wr_reg(2'd1, 2);
        wr_reg(2'd2, ctrl_word(1, 2'b10, 1, 2'b00, 0, 1, 1));
        pdata_in = 32'h1234_5678; ppar_in = ~good_par(32'h1234_5678); preq = 1; mready = 1; #1;
        chk(pack, "R8 bad parity still acked", pack, 1);
        chk(!mwr, "R8 no write on bad parity", mwr, 0);
        chk(!ptc, "R8 no terminal count on bad parity", ptc, 0);
        @(negedge clk); preq = 0; mready = 0;
        rd_reg(2'd3, r); chk(r[2] == 1'b1, "R8 parity error set", r, 4);
        rd_reg(2'd2, r); chk(r[0] == 1'b0, "R8 enable cleared", r[0], 0);
        rd_reg(2'd1, r); chk(r == 2, "R8 count unchanged", r, 2);
        rd_reg(2'd0, r); chk(r == 32'h200, "R8 address unchanged", r, 32'h200);
        wr_reg(2'd3, 32'h7);

        // random runs: R3 R4 R5 R6 R8
        for (int run = 0; run < 40; run++) begin
            logic [1:0]  w;
            bit          dinc, dir, pen;
            logic [31:0] eaddr;
            int          ecnt, stp, guard;
            w    = 2'($urandom_range(0, 3));
            dinc = 1'($urandom);
            dir  = 1'($urandom);
            pen  = 1'($urandom);
            stp  = step_of(w);
            eaddr = ($urandom & 32'h0000_FFF0) | 32'h1000;
            ecnt = $urandom_range(1, 12);
            wr_reg(2'd0, eaddr);
            wr_reg(2'd1, 32'(ecnt));
            wr_reg(2'd2, ctrl_word(1, w, dinc, 2'b00, 0, dir, pen));
            guard = 0;
            while (ecnt > 0 && guard < 400) begin
                bit exp_x;
                @(negedge clk);
                preq     = 1'($urandom_range(0, 3) != 0);
                mready   = 1'($urandom_range(0, 3) != 0);
                pdata_in = $urandom;
                mrdata   = $urandom;
                ppar_in  = pen ? good_par(pdata_in) : 4'($urandom);
                #1;
                exp_x = preq && mready;
                chk(pack == exp_x, "R3 ack", pack, exp_x);
                chk(mwr == (exp_x && dir), "R4 memory write strobe", mwr, exp_x && dir);
                chk(mrd == (exp_x && !dir), "R4 memory read strobe", mrd, exp_x && !dir);
                if (exp_x) begin
                    chk(maddr == eaddr, "R5 memory address", maddr, eaddr);
                    chk(ptc == (ecnt == 1), "R6 terminal count timing", ptc, ecnt == 1);
                    if (dir) chk(mwdata == pdata_in, "R4 write data path", mwdata, pdata_in);
                    else     chk(pdata_out == mrdata, "R4 read data path", pdata_out, mrdata);
                    ecnt--;
                    if (dinc) eaddr += stp;
                end else begin
                    chk(!ptc, "R6 no terminal count without ack", ptc, 0);
                    chk(pdata_out == 0, "R4 idle peripheral output", pdata_out, 0);
                end
                guard++;
            end
            @(negedge clk);
            preq = 0; mready = 0; #1;
            chk(!ptc, "R6 terminal count dropped", ptc, 0);
            rd_reg(2'd3, r); chk(r == 1, "R6 done bit", r, 1);
            rd_reg(2'd2, r); chk(r[0] == 0, "R6 enable cleared", r[0], 0);
            rd_reg(2'd0, r); chk(r == eaddr, "R5 final address", r, eaddr);
            rd_reg(2'd1, r); chk(r == 0, "R6 count zero", r, 0);
            wr_reg(2'd3, 32'h1);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule